// File: doc/BRIEF.md
# Port Group Forwarding Mask Resolver

This block works out the egress port mask for each frame in a small Layer-2 switch. It holds one table of port-group masks. Each entry is one bit wider than the number of physical ports, and the extra top bit stands for the CPU port. Every frame is resolved with three reads of that table:

- a destination read, which picks the candidate ports;
- an aggregation read, indexed by the frame's 4-bit aggregation code, which leaves one member of each link aggregation group;
- a source read, indexed by the ingress port, which applies the port-to-port forwarding matrix.

The result is the bitwise AND of the three masks.

The destination index comes from the MAC-table result when the address lookup hit. When it missed, the index is a flood entry chosen by the frame's traffic class. Descriptors arrive on a valid/ready handshake and results leave on another. A host write/read port reaches any table entry, and a host access always takes the table port ahead of the lookup.

Top module: `pgm_resolver`

## Requirements
- R1: After reset `res_valid_o` and `cfg_rvalid_o` are low and `desc_ready_o` is high.
- R2: After reset the table holds the following values, with N = NUM_PORTS and bit N the CPU bit:
  - entry i < N is the one-hot mask with bit i;
  - entry 58 is the CPU bit alone;
  - entries 59..63 are all ones;
  - the other destination entries (N..57) are zero;
  - aggregation entries 64..79 are all ones;
  - source entry 80+i is all ones except bit i.
- R3: The result mask equals `tbl[d] & tbl[64+aggr] & tbl[80+port]`, where d is the destination index. Any index above 90 reads as zero.
- R4: With `desc_hit_i`=1 the destination index is `desc_dst_i`, in the range 0..63.
- R5: With `desc_hit_i`=0 the destination index is chosen by `desc_cls_i`:
  - 0 (unknown unicast) selects 59;
  - 1 (non-IP multicast) selects 60;
  - 2 (IPv4 multicast) selects 61;
  - 3 (IPv6 multicast) selects 62;
  - 4 (broadcast) selects 63;
  - 5, 6 and 7 select the CPU entry, 58.
- R6: The aggregation entry at 64 + `desc_aggr_i` narrows a multi-port destination to the member ports it keeps.
- R7: A cleared bit j in source entry 80+i removes port j from every result for ingress port i. Bit N, the CPU, is forwarded like any other bit.
- R8: Without host traffic, `res_valid_o` rises on the fourth rising edge after the descriptor handshake. It then stays high, with `res_mask_o` unchanged, until `res_ready_i` is sampled high.
- R9: While `cfg_we_i` is high, `desc_ready_o` is low. A write in the middle of a frame delays that frame by one cycle, and the frame's later reads see the new value.
- R10: A write to an index above 90 changes no entry. A read of such an index returns zero.
- R11: A host read (`cfg_re_i` with `cfg_we_i` low) sets `cfg_rvalid_o` on the next edge, with `cfg_rdata_o` holding the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_ready_o | output | 1 | Descriptor accepted when high together with valid |
| desc_hit_i | input | 1 | MAC-table lookup hit |
| desc_dst_i | input | 6 | Destination entry index from the MAC table |
| desc_cls_i | input | 3 | Traffic class used when the lookup missed |
| desc_aggr_i | input | 4 | Link aggregation code |
| desc_port_i | input | 4 | Ingress port number (N is the CPU) |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumed |
| res_mask_o | output | 11 | Egress mask, CPU bit on top |
| cfg_we_i | input | 1 | Host table write |
| cfg_re_i | input | 1 | Host table read |
| cfg_idx_i | input | 7 | Host entry index |
| cfg_wdata_i | input | 11 | Host write data |
| cfg_rvalid_o | output | 1 | Host read data valid |
| cfg_rdata_o | output | 11 | Host read data |

## Verification
The hardest situation to reach from the ports is a host write that lands between two of a frame's own table reads. Only that case shows that the stalled sequencer resumes in the right place and picks up the new entry. The bench accepts a frame, waits exactly one cycle, and then writes that frame's source entry. It expects the result one cycle late and masked by the new value. Random host writes mixed with random frames then check the three-way AND against a bench copy of the table.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int unsigned DST_IDX_W = 6;
  localparam int unsigned AGG_W     = 4;
  localparam int unsigned CLS_W     = 3;
  localparam int unsigned AGG_BASE  = 64;
  localparam int unsigned SRC_BASE  = 80;
  localparam int unsigned CPU_ENTRY = 58;
  localparam int unsigned FLOOD_LO  = 59;
  localparam int unsigned FLOOD_HI  = 63;

  typedef enum logic [CLS_W-1:0] {
    CLS_UCAST = 3'd0,
    CLS_L2MC  = 3'd1,
    CLS_IP4MC = 3'd2,
    CLS_IP6MC = 3'd3,
    CLS_BCAST = 3'd4,
    CLS_CPU   = 3'd5
  } miss_cls_e;
endpackage

// File: rtl/pgm_table.sv
module pgm_table
  import pgm_pkg::*;
#(
  parameter int unsigned NP    = 10,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [NP:0]      wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [NP:0]      rd_data_o
);
  localparam int unsigned W       = NP + 1;
  localparam int unsigned ENTRIES = SRC_BASE + NP + 1;
  localparam int unsigned LAST    = ENTRIES - 1;

  logic [W-1:0] mem_q [ENTRIES];
  logic [W-1:0] rd_q;

  function automatic logic [W-1:0] rst_val(int e);
    if (e < int'(NP))                                return W'(1) << e;
    else if (e == int'(CPU_ENTRY))                   return W'(1) << NP;
    else if (e >= int'(FLOOD_LO) && e <= int'(FLOOD_HI)) return '1;
    else if (e < int'(AGG_BASE))                     return '0;
    else if (e < int'(SRC_BASE))                     return '1;
    else                                             return ~(W'(1) << (e - int'(SRC_BASE)));
  endfunction

  wire wr_ok = wr_en_i && (int'(wr_idx_i) <= int'(LAST));
  wire rd_ok = int'(rd_idx_i) <= int'(LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(ENTRIES); e++) mem_q[e] <= rst_val(e);
    end else if (wr_ok) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_ok ? mem_q[rd_idx_i] : '0;
  end

  assign rd_data_o = rd_q;

  // R10
  oob_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_ok) |=> (rd_data_o == '0));
  // R9
  single_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));
endmodule

// File: rtl/pgm_index_gen.sv
module pgm_index_gen
  import pgm_pkg::*;
#(
  parameter int unsigned PORT_W   = 4,
  parameter int unsigned IDX_W    = 7,
  parameter int unsigned FL_CPU   = 58,
  parameter int unsigned FL_UCAST = 59,
  parameter int unsigned FL_L2MC  = 60,
  parameter int unsigned FL_IP4MC = 61,
  parameter int unsigned FL_IP6MC = 62,
  parameter int unsigned FL_BCAST = 63
) (
  input  logic                 hit_i,
  input  logic [DST_IDX_W-1:0] dst_i,
  input  logic [CLS_W-1:0]     cls_i,
  input  logic [AGG_W-1:0]     aggr_i,
  input  logic [PORT_W-1:0]    port_i,
  output logic [IDX_W-1:0]     dst_idx_o,
  output logic [IDX_W-1:0]     agg_idx_o,
  output logic [IDX_W-1:0]     src_idx_o
);
  logic [IDX_W-1:0] flood_idx;

  always_comb begin
    unique case (miss_cls_e'(cls_i))
      CLS_UCAST: flood_idx = IDX_W'(FL_UCAST);
      CLS_L2MC:  flood_idx = IDX_W'(FL_L2MC);
      CLS_IP4MC: flood_idx = IDX_W'(FL_IP4MC);
      CLS_IP6MC: flood_idx = IDX_W'(FL_IP6MC);
      CLS_BCAST: flood_idx = IDX_W'(FL_BCAST);
      default:   flood_idx = IDX_W'(FL_CPU);
    endcase
  end

  assign dst_idx_o = hit_i ? IDX_W'(dst_i) : flood_idx;
  assign agg_idx_o = IDX_W'(AGG_BASE) + IDX_W'(aggr_i);
  assign src_idx_o = IDX_W'(SRC_BASE) + IDX_W'(port_i);
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq #(
  parameter int unsigned NP    = 10,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  logic [IDX_W-1:0] agg_idx_i,
  input  logic [IDX_W-1:0] src_idx_i,
  output logic             rd_req_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             gnt_i,
  input  logic [NP:0]      rd_data_i,
  output logic             busy_o,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [NP:0]      res_mask_o
);
  localparam int unsigned NREADS = 3;
  localparam int unsigned CNT_W  = $clog2(NREADS + 1);

  logic [IDX_W-1:0] idx_q [NREADS];
  logic [CNT_W-1:0] n_iss_q, n_got_q;
  logic             busy_q, pend_q, valid_q;
  logic [NP:0]      acc_q, mask_q;

  assign rd_req_o = busy_q && (n_iss_q != CNT_W'(NREADS));

  always_comb begin
    case (n_iss_q)
      CNT_W'(0): rd_idx_o = idx_q[0];
      CNT_W'(1): rd_idx_o = idx_q[1];
      default:   rd_idx_o = idx_q[2];
    endcase
  end

  wire issue = rd_req_o && gnt_i;
  wire last  = pend_q && (n_got_q == CNT_W'(NREADS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(NREADS); k++) idx_q[k] <= '0;
      n_iss_q <= '0;
      n_got_q <= '0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      acc_q   <= '0;
      mask_q  <= '0;
    end else begin
      pend_q <= issue;
      if (issue) n_iss_q <= n_iss_q + CNT_W'(1);
      // capture own read data even when the port is taken by the host
      if (pend_q) begin
        acc_q   <= (n_got_q == '0) ? rd_data_i : (acc_q & rd_data_i);
        n_got_q <= n_got_q + CNT_W'(1);
      end
      if (valid_q && res_ready_i) valid_q <= 1'b0;
      if (last) begin
        mask_q  <= acc_q & rd_data_i;
        valid_q <= 1'b1;
        busy_q  <= 1'b0;
      end
      if (start_i) begin
        idx_q[0] <= dst_idx_i;
        idx_q[1] <= agg_idx_i;
        idx_q[2] <= src_idx_i;
        n_iss_q  <= '0;
        n_got_q  <= '0;
        busy_q   <= 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign res_valid_o = valid_q;
  assign res_mask_o  = mask_q;

  // R8
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !res_ready_i) |=> (valid_q && $stable(mask_q)));
  // R8
  read_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_got_q <= n_iss_q) && (n_iss_q <= CNT_W'(NREADS)));
  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!busy_q && !pend_q));
endmodule

// File: rtl/pgm_resolver.sv
module pgm_resolver
  import pgm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 10,
  parameter int unsigned FL_CPU    = 58,
  parameter int unsigned FL_UCAST  = 59,
  parameter int unsigned FL_L2MC   = 60,
  parameter int unsigned FL_IP4MC  = 61,
  parameter int unsigned FL_IP6MC  = 62,
  parameter int unsigned FL_BCAST  = 63,
  localparam int unsigned W        = NUM_PORTS + 1,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS + 1),
  localparam int unsigned IDX_W    = $clog2(SRC_BASE + NUM_PORTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 desc_valid_i,
  output logic                 desc_ready_o,
  input  logic                 desc_hit_i,
  input  logic [DST_IDX_W-1:0] desc_dst_i,
  input  logic [CLS_W-1:0]     desc_cls_i,
  input  logic [AGG_W-1:0]     desc_aggr_i,
  input  logic [PORT_W-1:0]    desc_port_i,
  output logic                 res_valid_o,
  input  logic                 res_ready_i,
  output logic [W-1:0]         res_mask_o,
  input  logic                 cfg_we_i,
  input  logic                 cfg_re_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [W-1:0]         cfg_wdata_i,
  output logic                 cfg_rvalid_o,
  output logic [W-1:0]         cfg_rdata_o
);
  logic [IDX_W-1:0] dst_idx, agg_idx, src_idx, seq_idx, tbl_rd_idx;
  logic             seq_req, seq_busy, tbl_rd_en, host_rd, start, rvalid_q;
  logic [W-1:0]     tbl_rd_data;

  assign host_rd    = cfg_re_i && !cfg_we_i;
  assign tbl_rd_en  = !cfg_we_i && (cfg_re_i || seq_req);
  assign tbl_rd_idx = cfg_re_i ? cfg_idx_i : seq_idx;

  assign desc_ready_o = !seq_busy && (!res_valid_o || res_ready_i) && !cfg_we_i;
  assign start        = desc_valid_i && desc_ready_o;

  pgm_index_gen #(
    .PORT_W(PORT_W), .IDX_W(IDX_W), .FL_CPU(FL_CPU), .FL_UCAST(FL_UCAST),
    .FL_L2MC(FL_L2MC), .FL_IP4MC(FL_IP4MC), .FL_IP6MC(FL_IP6MC), .FL_BCAST(FL_BCAST)
  ) i_index_gen (
    .hit_i(desc_hit_i), .dst_i(desc_dst_i), .cls_i(desc_cls_i),
    .aggr_i(desc_aggr_i), .port_i(desc_port_i),
    .dst_idx_o(dst_idx), .agg_idx_o(agg_idx), .src_idx_o(src_idx)
  );

  pgm_table #(.NP(NUM_PORTS), .IDX_W(IDX_W)) i_table (
    .clk_i, .rst_ni,
    .wr_en_i(cfg_we_i), .wr_idx_i(cfg_idx_i), .wr_data_i(cfg_wdata_i),
    .rd_en_i(tbl_rd_en), .rd_idx_i(tbl_rd_idx), .rd_data_o(tbl_rd_data)
  );

  pgm_seq #(.NP(NUM_PORTS), .IDX_W(IDX_W)) i_seq (
    .clk_i, .rst_ni, .start_i(start),
    .dst_idx_i(dst_idx), .agg_idx_i(agg_idx), .src_idx_i(src_idx),
    .rd_req_o(seq_req), .rd_idx_o(seq_idx), .gnt_i(!cfg_we_i && !cfg_re_i),
    .rd_data_i(tbl_rd_data), .busy_o(seq_busy),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_mask_o(res_mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= host_rd;
  end

  assign cfg_rvalid_o = rvalid_q;
  assign cfg_rdata_o  = tbl_rd_data;

  // R8
  accept_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !res_valid_o);
  // R11
  host_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rvalid_o |-> $past(cfg_re_i));
endmodule

// File: tb/test_pgm_resolver.sv
module test_pgm_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 10;
  localparam int W = NP + 1;
  localparam int LAST = 90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 0, desc_hit = 0, res_ready = 1, cfg_we = 0, cfg_re = 0;
  logic [5:0] desc_dst = '0;
  logic [2:0] desc_cls = '0;
  logic [3:0] desc_aggr = '0, desc_port = '0;
  logic [6:0] cfg_idx = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic desc_ready, res_valid, cfg_rvalid;
  logic [W-1:0] res_mask, cfg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgm_resolver i_pgm_resolver (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready), .desc_hit_i(desc_hit),
    .desc_dst_i(desc_dst), .desc_cls_i(desc_cls), .desc_aggr_i(desc_aggr),
    .desc_port_i(desc_port), .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_mask_o(res_mask), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .cfg_rvalid_o(cfg_rvalid), .cfg_rdata_o(cfg_rdata)
  );

  logic [W-1:0] model [0:LAST];
  int errs = 0;
  int checks = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rst_val(int e);
    if (e < NP) return W'(1) << e;
    if (e == 58) return W'(1) << NP;
    if (e >= 59 && e <= 63) return '1;
    if (e < 64) return '0;
    if (e < 80) return '1;
    return ~(W'(1) << (e - 80));
  endfunction

  function automatic int flood_idx(int cls);
    case (cls)
      0: return 59;
      1: return 60;
      2: return 61;
      3: return 62;
      4: return 63;
      default: return 58;
    endcase
  endfunction

  function automatic logic [W-1:0] ent(int i);
    return (i <= LAST) ? model[i] : '0;
  endfunction

  function automatic logic [W-1:0] exp_mask(bit hit, int dst, int cls, int agg, int port);
    int d = hit ? dst : flood_idx(cls);
    return ent(d) & ent(64 + agg) & ent(80 + port);
  endfunction

  task automatic host_wr(int idx, logic [W-1:0] data);
    cfg_we = 1; cfg_idx = 7'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
    if (idx <= LAST) model[idx] = data;
  endtask

  task automatic host_rd(int idx, logic [W-1:0] exp, string tag);
    cfg_re = 1; cfg_idx = 7'(idx);
    @(negedge clk);
    cfg_re = 0;
    chk(cfg_rvalid === 1'b1, tag, 32'(cfg_rvalid), 1);
    chk(cfg_rdata === exp, tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic send_frame(bit hit, int dst, int cls, int agg, int port, string tag, int hold);
    logic [W-1:0] e;
    desc_valid = 1; desc_hit = hit; desc_dst = 6'(dst); desc_cls = 3'(cls);
    desc_aggr = 4'(agg); desc_port = 4'(port);
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 0;
    e = exp_mask(hit, dst, cls, agg, port);
    if (hold > 0) res_ready = 0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(res_valid === 1'b0, "R8 early", 32'(res_valid), 0);
    end
    @(negedge clk);
    chk(res_valid === 1'b1, "R8 latency", 32'(res_valid), 1);
    chk(res_mask === e, tag, 32'(res_mask), 32'(e));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(res_valid === 1'b1 && res_mask === e, "R8 hold", 32'(res_mask), 32'(e));
    end
    if (hold > 0) begin
      res_ready = 1;
      @(negedge clk);
      chk(res_valid === 1'b0, "R8 release", 32'(res_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] e;
    int r;
    for (int i = 0; i <= LAST; i++) model[i] = rst_val(i);
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(desc_ready === 1'b1, "R1 ready", 32'(desc_ready), 1);
    chk(res_valid === 1'b0, "R1 res_valid", 32'(res_valid), 0);
    chk(cfg_rvalid === 1'b0, "R1 rvalid", 32'(cfg_rvalid), 0);
    // R2 reset contents, R11 host read
    foreach (model[i]) if (i inside {0, 3, 9, 10, 57, 58, 59, 63, 64, 79, 80, 85, 90})
      host_rd(i, rst_val(i), "R2 reset entry");
    // R4 hit
    send_frame(1, 3, 0, 0, 0, "R4 hit", 0);
    send_frame(1, 58, 0, 5, 2, "R4 hit cpu entry", 0);
    // R5 every miss class
    for (int c = 0; c < 8; c++) send_frame(0, 0, c, 1, 2, "R5 miss class", 0);
    host_wr(60, 11'h00f);
    host_wr(62, 11'h3c0);
    send_frame(0, 0, 1, 0, 4, "R5 l2mc flood", 0);
    send_frame(0, 0, 3, 0, 4, "R5 ip6mc flood", 0);
    // R6 link aggregation with members 4,5,6
    host_wr(20, 11'h070);
    host_wr(64, ~11'h060);
    host_wr(65, ~11'h050);
    host_wr(66, ~11'h030);
    send_frame(1, 20, 0, 0, 1, "R6 lag code0", 0);
    send_frame(1, 20, 0, 1, 1, "R6 lag code1", 0);
    send_frame(1, 20, 0, 2, 1, "R6 lag code2", 0);
    chk(exp_mask(1, 20, 0, 2, 1) == 11'h040, "R6 model", 32'(exp_mask(1, 20, 0, 2, 1)), 32'h40);
    // R7 blocked pair and CPU bit
    host_wr(81, ~11'h082);
    send_frame(1, 7, 0, 3, 1, "R7 blocked", 0);
    send_frame(0, 0, 4, 3, 1, "R7 flood minus blocked", 0);
    send_frame(0, 0, 4, 3, 10, "R7 cpu ingress", 0);
    host_wr(83, ~11'h408);
    send_frame(1, 58, 0, 3, 3, "R7 cpu bit blocked", 0);
    // R10 out of range
    host_wr(95, '1);
    host_rd(95, '0, "R10 oob read");
    host_rd(127, '0, "R10 oob read top");
    send_frame(0, 0, 4, 0, 12, "R10 oob source", 0);
    send_frame(1, 31, 0, 15, 0, "R10 entries intact", 0);
    // R9 write blocks descriptor ready
    cfg_we = 1; cfg_idx = 7'd100; desc_valid = 1;
    #1;
    chk(desc_ready === 1'b0, "R9 ready low on write", 32'(desc_ready), 0);
    @(negedge clk);
    cfg_we = 0; desc_valid = 0;
    // R9 write between a frame's reads
    desc_valid = 1; desc_hit = 0; desc_cls = 3'd4; desc_aggr = 4'd7; desc_port = 4'd5;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 0;
    @(negedge clk);
    cfg_we = 1; cfg_idx = 7'd85; cfg_wdata = 11'h00c;
    @(negedge clk);
    cfg_we = 0; model[85] = 11'h00c;
    e = exp_mask(0, 0, 4, 7, 5);
    @(negedge clk);
    @(negedge clk);
    chk(res_valid === 1'b0, "R9 stalled", 32'(res_valid), 0);
    @(negedge clk);
    chk(res_valid === 1'b1, "R9 delayed valid", 32'(res_valid), 1);
    chk(res_mask === e, "R9 new entry seen", 32'(res_mask), 32'(e));
    @(negedge clk);
    // R8 backpressure
    send_frame(1, 2, 0, 9, 0, "R8 hold frame", 3);
    // R3 random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 2) == 0) host_wr($urandom_range(0, 100), W'($urandom));
      if ($urandom_range(0, 5) == 0) begin
        int ri = $urandom_range(0, LAST);
        host_rd(ri, model[ri], "R11 random read");
      end
      send_frame(1'($urandom), $urandom_range(0, 63), $urandom_range(0, 7),
                 $urandom_range(0, 15), $urandom_range(0, 10), "R3 random", 0);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule